// File: doc/BRIEF.md
# Packed BCD Subtract-with-Extend Unit

This unit carries out one byte-wide decimal subtraction per instruction. It takes a 16-bit instruction word, checks it against a fixed opcode pattern, and finds its source and destination operands. It then computes destination minus source minus the extend flag in packed two-digit BCD, stores the result in the destination, and updates the extend, zero and carry flags. The unit holds its own file of eight 32-bit data registers and eight 32-bit address registers. A load port and a read port give access to that file, and a separate port presets the five-bit flag register.

The instruction chooses one of two operand paths.
- **Register path:** the low bytes of two data registers are the operands. Only the low byte of the destination register is rewritten.
- **Memory path:** two address registers are each stepped downward before use. The unit reads the source byte, then reads the destination byte, then writes the result back. Every byte access completes on a valid/ready handshake.

The zero flag is only ever cleared. Software can therefore preset it and chain several instructions over a multi-byte decimal number. After the chain, the flag still reads 1 only if every byte of the result was zero.

The controller is a state machine with six states:
- **S_IDLE:** waits for `start`.
- **S_SRC_RD:** fetches the source byte.
- **S_DST_RD:** fetches the destination byte.
- **S_EXEC:** computes the result and updates the flags.
- **S_WRITE:** stores the result to memory.
- **S_DONE:** raises the completion pulse.

Its transitions are:
- **go_reg:** S_IDLE to S_EXEC, on a legal start with the mode bit clear.
- **go_mem:** S_IDLE to S_SRC_RD, on a legal start with the mode bit set.
- **src_ack:** S_SRC_RD to S_DST_RD, when the handshake completes.
- **dst_ack:** S_DST_RD to S_EXEC, when the handshake completes.
- **exec_mem:** S_EXEC to S_WRITE.
- **exec_reg:** S_EXEC to S_DONE.
- **wr_ack:** S_WRITE to S_DONE, when the handshake completes.
- **finish:** S_DONE to S_IDLE.

Top module: `bcd_sub_unit`

## Requirements
- R1: The result byte equals (destination − source − X) in packed BCD, taken modulo 100, and is written to the destination. Bits 7:4 hold the tens digit and bits 3:0 the units digit.
- R2: C becomes 1 when the subtraction borrows out of the tens digit and 0 otherwise. X always takes the value of C. Flag register bit order is {X,N,Z,V,C}, with X at bit 4 and C at bit 0. For example, 00 − 01 with X=0 gives 99 with C=X=1.
- R3: A nonzero result clears Z. A zero result leaves Z at its prior value, whether that value is 0 or 1.
- R4: N (bit 3) and V (bit 1) are never altered by an instruction.
- R5: In register mode (instruction bit 3 = 0), bits 2:0 name the source data register and bits 11:9 name the destination data register. Only bits 7:0 of the destination register change, and the source register keeps its value.
- R6: An instruction is legal only when bits 15:12 = 1000 and bits 8:4 = 10000. Any other start raises `illegal` for exactly one cycle, and nothing else changes: registers, flags, memory and `done` stay as they were.
- R7: In memory mode (bit 3 = 1), the access order is: read the source at the stepped-down value of the source address register, then read the destination at the stepped-down value of the destination address register, then write the result to that same destination address.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request (address, write flag, write data) holds steady.
- R9: The step-down amount is 1 for address registers 0 to 6 and 2 for register 7. When source and destination name the same register, that register is stepped down twice, once before each read.
- R10: `done` is high for exactly one cycle when an instruction completes. A `start` that arrives while an instruction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept `instr` when the unit is idle |
| instr | input | 16 | Instruction word |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |
| done | output | 1 | One-cycle completion pulse |
| ccr | output | 5 | Flags {X,N,Z,V,C} |
| ccr_wr_en | input | 1 | Preset the flags |
| ccr_wr_data | input | 5 | Preset value for the flags |
| reg_wr_en | input | 1 | Load a register |
| reg_wr_sel | input | 4 | Register to load: bit 3 = 1 selects an address register, bits 2:0 give its index |
| reg_wr_data | input | 32 | Load value |
| reg_rd_sel | input | 4 | Register to read, same encoding as `reg_wr_sel` |
| reg_rd_data | output | 32 | Contents of the register selected by `reg_rd_sel` |
| mem_req_valid | output | 1 | Byte access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid while ready is high |

## Verification
In one cycle the unit can both complete a handshake and step down an address register. If source and destination name the same address register, the source read is accepted in the very cycle that the same register is decremented again for the destination read. The bench provokes this with a memory-mode instruction that uses the same address register on both sides while the memory responder stalls. It judges the outcome from the logged access addresses (two successive addresses, one apart) and from the final register value. A second overlap is a preset of the flags in the same cycle as S_EXEC: the instruction's flag update takes precedence. This path is exercised indirectly through the sticky-zero chains.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;
    localparam int IDX_W = 3;
    localparam int SEL_W = IDX_W + 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SRC_RD,
        S_DST_RD,
        S_EXEC,
        S_WRITE,
        S_DONE
    } state_t;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;
endpackage

// File: rtl/bcd_digit_sub.sv
module bcd_digit_sub #(
    parameter int NDIG = 2
) (
    input  logic [4*NDIG-1:0] minuend,
    input  logic [4*NDIG-1:0] subtrahend,
    input  logic              borrow_in,
    output logic [4*NDIG-1:0] diff,
    output logic              borrow_out
);
    logic [NDIG:0] bw;
    assign bw[0] = borrow_in;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [4:0] raw;
        assign raw = {1'b0, minuend[4*g +: 4]} - {1'b0, subtrahend[4*g +: 4]}
                     - {4'b0, bw[g]};
        assign bw[g+1] = raw[4];
        assign diff[4*g +: 4] = raw[4] ? (raw[3:0] - 4'd6) : raw[3:0];
    end

    assign borrow_out = bw[NDIG];
endmodule

// File: rtl/bcd_regfile.sv
module bcd_regfile
    import bcd_sub_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rd0_sel,
    output logic [REG_W-1:0] rd0_data,
    input  logic [SEL_W-1:0] rd1_sel,
    output logic [REG_W-1:0] rd1_data,
    input  logic [SEL_W-1:0] rd2_sel,
    output logic [REG_W-1:0] rd2_data,
    input  logic             cw_en,
    input  logic [SEL_W-1:0] cw_sel,
    input  logic [REG_W-1:0] cw_data,
    input  logic             xw_en,
    input  logic [SEL_W-1:0] xw_sel,
    input  logic [REG_W-1:0] xw_data
);
    localparam int NREG = 1 << IDX_W;

    logic [REG_W-1:0] dreg [NREG];
    logic [REG_W-1:0] areg [NREG];

    function automatic logic [REG_W-1:0] pick(input logic [SEL_W-1:0] s,
                                             input logic [REG_W-1:0] d [NREG],
                                             input logic [REG_W-1:0] a [NREG]);
        return s[IDX_W] ? a[s[IDX_W-1:0]] : d[s[IDX_W-1:0]];
    endfunction

    assign rd0_data = pick(rd0_sel, dreg, areg);
    assign rd1_data = pick(rd1_sel, dreg, areg);
    assign rd2_data = pick(rd2_sel, dreg, areg);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dreg[i] <= '0;
                areg[i] <= '0;
            end else if (cw_en && cw_sel[IDX_W-1:0] == IDX_W'(i)) begin
                if (cw_sel[IDX_W]) areg[i] <= cw_data;
                else               dreg[i] <= cw_data;
            end else if (xw_en && xw_sel[IDX_W-1:0] == IDX_W'(i)) begin
                if (xw_sel[IDX_W]) areg[i] <= xw_data;
                else               dreg[i] <= xw_data;
            end
        end
    end

    // A controller write lands in the next cycle even when a load collides
    assert_ctrl_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && rd2_sel == cw_sel) |=> (rd2_data == $past(cw_data) || rd2_sel != $past(cw_sel)));
endmodule

// File: rtl/bcd_sub_ctrl.sv
module bcd_sub_ctrl
    import bcd_sub_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [15:0]      instr,
    output logic             illegal,
    output logic             done,
    output logic [4:0]       ccr,
    input  logic             ccr_wr_en,
    input  logic [4:0]       ccr_wr_data,
    output logic [SEL_W-1:0] src_sel,
    output logic [SEL_W-1:0] dst_sel,
    input  logic [REG_W-1:0] src_val,
    input  logic [REG_W-1:0] dst_val,
    output logic             rf_we,
    output logic [SEL_W-1:0] rf_wsel,
    output logic [REG_W-1:0] rf_wdata,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    state_t state_q, state_d;
    logic [IDX_W-1:0] rx_q, ry_q, rx_f, ry_f;
    logic             rm_q, rm_f;
    logic [7:0]       src_q, dst_q, res_q, diff;
    logic             borrow, illegal_q, legal, take;
    ccr_t             ccr_q;

    function automatic logic [REG_W-1:0] step_of(input logic [IDX_W-1:0] i);
        return (i == IDX_W'((1 << IDX_W) - 1)) ? REG_W'(2) : REG_W'(1);
    endfunction

    assign legal = (instr[15:12] == 4'b1000) && (instr[8:4] == 5'b10000);
    assign take  = (state_q == S_IDLE) && start;
    assign rx_f  = (state_q == S_IDLE) ? instr[2:0]  : rx_q;
    assign ry_f  = (state_q == S_IDLE) ? instr[11:9] : ry_q;
    assign rm_f  = (state_q == S_IDLE) ? instr[3]    : rm_q;
    assign src_sel = {rm_f, rx_f};
    assign dst_sel = {rm_f, ry_f};

    bcd_digit_sub #(.NDIG(2)) u_digits (
        .minuend   (dst_q),
        .subtrahend(src_q),
        .borrow_in (ccr_q.x),
        .diff      (diff),
        .borrow_out(borrow)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (take && legal) state_d = instr[3] ? S_SRC_RD : S_EXEC;
            S_SRC_RD: if (mem_req_ready) state_d = S_DST_RD;
            S_DST_RD: if (mem_req_ready) state_d = S_EXEC;
            S_EXEC:   state_d = rm_q ? S_WRITE : S_DONE;
            S_WRITE:  if (mem_req_ready) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rf_we         = 1'b0;
        rf_wsel       = '0;
        rf_wdata      = '0;
        mem_req_valid = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = '0;
        mem_wdata     = '0;
        done          = 1'b0;
        unique case (state_q)
            S_IDLE: if (take && legal && instr[3]) begin
                rf_we    = 1'b1;
                rf_wsel  = src_sel;
                rf_wdata = src_val - step_of(rx_f);
            end
            S_SRC_RD: begin
                mem_req_valid = 1'b1;
                mem_addr      = src_val;
                if (mem_req_ready) begin
                    rf_we    = 1'b1;
                    rf_wsel  = dst_sel;
                    rf_wdata = dst_val - step_of(ry_q);
                end
            end
            S_DST_RD: begin
                mem_req_valid = 1'b1;
                mem_addr      = dst_val;
            end
            S_EXEC: if (!rm_q) begin
                rf_we    = 1'b1;
                rf_wsel  = dst_sel;
                rf_wdata = {dst_val[REG_W-1:8], diff};
            end
            S_WRITE: begin
                mem_req_valid = 1'b1;
                mem_we        = 1'b1;
                mem_addr      = dst_val;
                mem_wdata     = res_q;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    // datapath and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0; ry_q <= '0; rm_q <= 1'b0;
            src_q <= '0; dst_q <= '0; res_q <= '0;
            illegal_q <= 1'b0;
            ccr_q <= '0;
        end else begin
            illegal_q <= take && !legal;
            if (take && legal) begin
                rx_q <= instr[2:0];
                ry_q <= instr[11:9];
                rm_q <= instr[3];
                if (!instr[3]) begin
                    src_q <= src_val[7:0];
                    dst_q <= dst_val[7:0];
                end
            end
            if (state_q == S_SRC_RD && mem_req_ready) src_q <= mem_rdata;
            if (state_q == S_DST_RD && mem_req_ready) dst_q <= mem_rdata;
            if (state_q == S_EXEC) begin
                res_q   <= diff;
                ccr_q.c <= borrow;
                ccr_q.x <= borrow;
                if (diff != 8'h00) ccr_q.z <= 1'b0;
            end else if (ccr_wr_en) begin
                ccr_q <= ccr_t'(ccr_wr_data);
            end
        end
    end

    assign illegal = illegal_q;
    assign ccr     = ccr_q;

    assert_x_follows_c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC) |=> (ccr_q.x == ccr_q.c));
    assert_zero_keeps_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && diff == 8'h00) |=> (ccr_q.z == $past(ccr_q.z)));
    assert_nonzero_clears_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && diff != 8'h00) |=> !ccr_q.z);
    assert_nv_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC) |=> (ccr_q.n == $past(ccr_q.n) && ccr_q.v == $past(ccr_q.v)));
    assert_illegal_no_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (state_q == S_IDLE));
    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    assert_first_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && legal && instr[3]) |=> (src_val == $past(src_val - step_of(instr[2:0]))));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/bcd_sub_unit.sv
module bcd_sub_unit
    import bcd_sub_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [15:0]      instr,
    output logic             illegal,
    output logic             done,
    output logic [4:0]       ccr,
    input  logic             ccr_wr_en,
    input  logic [4:0]       ccr_wr_data,
    input  logic             reg_wr_en,
    input  logic [SEL_W-1:0] reg_wr_sel,
    input  logic [REG_W-1:0] reg_wr_data,
    input  logic [SEL_W-1:0] reg_rd_sel,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    logic [SEL_W-1:0] src_sel, dst_sel, rf_wsel;
    logic [REG_W-1:0] src_val, dst_val, rf_wdata;
    logic             rf_we;

    bcd_regfile #(.REG_W(REG_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd0_sel (src_sel),
        .rd0_data(src_val),
        .rd1_sel (dst_sel),
        .rd1_data(dst_val),
        .rd2_sel (reg_rd_sel),
        .rd2_data(reg_rd_data),
        .cw_en   (rf_we),
        .cw_sel  (rf_wsel),
        .cw_data (rf_wdata),
        .xw_en   (reg_wr_en),
        .xw_sel  (reg_wr_sel),
        .xw_data (reg_wr_data)
    );

    bcd_sub_ctrl #(.REG_W(REG_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .instr        (instr),
        .illegal      (illegal),
        .done         (done),
        .ccr          (ccr),
        .ccr_wr_en    (ccr_wr_en),
        .ccr_wr_data  (ccr_wr_data),
        .src_sel      (src_sel),
        .dst_sel      (dst_sel),
        .src_val      (src_val),
        .dst_val      (dst_val),
        .rf_we        (rf_we),
        .rf_wsel      (rf_wsel),
        .rf_wdata     (rf_wdata),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );
endmodule

// File: tb/bcd_sub_unit_bench.sv
module bcd_sub_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        illegal, done;
    logic [4:0]  ccr;
    logic        ccr_wr_en = 1'b0;
    logic [4:0]  ccr_wr_data = '0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic [3:0]  reg_rd_sel = '0;
    logic [31:0] reg_rd_data;
    logic        mem_req_valid, mem_we;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  mem_bytes [256];
    logic [31:0] log_addr [16];
    logic        log_we [16];
    int          log_n = 0;
    int          stall = 0;
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    int          done_cnt = 0;

    always #2.5 clk = ~clk;

    bcd_sub_unit u_bcd_sub_unit (.*);

    assign mem_rdata = mem_bytes[mem_addr[7:0]];

    always @(posedge clk) if (done) done_cnt++;

    always @(negedge clk) begin
        cyc++;
        mem_req_ready = (stall == 0) ? 1'b1 : ((cyc % 3) == 0);
        if (mem_req_valid && mem_req_ready) begin
            if (log_n < 16) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
                log_n++;
            end
            if (mem_we) mem_bytes[mem_addr[7:0]] = mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int ry, input int rm, input int rx);
        return 16'h8100 | 16'(ry << 9) | 16'(rm << 3) | 16'(rx);
    endfunction

    function automatic logic [8:0] ref_sub(input logic [7:0] d, input logic [7:0] s,
                                           input logic xin);
        int r;
        logic c;
        r = (d[7:4] * 10 + d[3:0]) - (s[7:4] * 10 + s[3:0]) - int'(xin);
        c = (r < 0);
        if (c) r += 100;
        return {c, 4'(r / 10), 4'(r % 10)};
    endfunction

    task automatic set_reg(input logic [3:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic get_reg(input logic [3:0] sel, output logic [31:0] v);
        reg_rd_sel = sel;
        #0.5;
        v = reg_rd_data;
    endtask

    task automatic set_ccr(input logic [4:0] v);
        @(negedge clk);
        ccr_wr_en = 1'b1; ccr_wr_data = v;
        @(negedge clk);
        ccr_wr_en = 1'b0;
    endtask

    task automatic run(input logic [15:0] i);
        int t;
        @(negedge clk);
        start = 1'b1; instr = i;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, "R10 done seen", 32'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", 32'(done), 0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        get_reg(4'h9, v);
        check(ccr == 5'b0 && !done && !illegal && !mem_req_valid && v == 0,
              "R10 reset state", {ccr, done, illegal, mem_req_valid}, 0);
    endtask

    task automatic t_reg_basic;
        logic [31:0] v;
        logic [8:0]  e;
        set_reg(4'h1, 32'h1234_5627);
        set_reg(4'h2, 32'hAABB_CC45);
        set_ccr(5'b00100);
        e = ref_sub(8'h45, 8'h27, 1'b0);
        run(enc(2, 0, 1));
        get_reg(4'h2, v);
        check(v == {24'hAABBCC, e[7:0]}, "R5 R1 reg result upper kept", v, {24'hAABBCC, e[7:0]});
        get_reg(4'h1, v);
        check(v == 32'h1234_5627, "R5 source unchanged", v, 32'h1234_5627);
        check(ccr == 5'b00000, "R2 R3 flags after 45-27", ccr, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        set_reg(4'h3, 32'h0000_0001);
        set_reg(4'h4, 32'hFFFF_FF00);
        set_ccr(5'b00100);
        run(enc(4, 0, 3));
        get_reg(4'h4, v);
        check(v == 32'hFFFF_FF99, "R1 00-01 wraps to 99", v, 32'hFFFF_FF99);
        check(ccr == 5'b10001, "R2 borrow sets C and X, R3 Z cleared", ccr, 5'b10001);
    endtask

    task automatic t_xin;
        logic [31:0] v;
        logic [8:0]  e;
        set_reg(4'h5, 32'h20);
        set_reg(4'h6, 32'h50);
        set_ccr(5'b10000);
        e = ref_sub(8'h50, 8'h20, 1'b1);
        run(enc(6, 0, 5));
        get_reg(4'h6, v);
        check(v[7:0] == e[7:0], "R1 X borrow in 50-20-1", v, e[7:0]);
        check(ccr[0] == e[8] && ccr[4] == e[8], "R2 no borrow clears C X", ccr, 0);
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        set_reg(4'h0, 32'h33);
        set_reg(4'h7, 32'h33);
        set_ccr(5'b00100);
        run(enc(7, 0, 0));
        get_reg(4'h7, v);
        check(v[7:0] == 8'h00 && ccr[2] == 1'b1, "R3 zero result keeps Z=1", ccr, 5'b00100);
        set_reg(4'h7, 32'h33);
        set_ccr(5'b00000);
        run(enc(7, 0, 0));
        check(ccr[2] == 1'b0, "R3 zero result keeps Z=0", ccr, 0);
    endtask

    task automatic t_nv;
        set_reg(4'h1, 32'h09);
        set_reg(4'h2, 32'h10);
        set_ccr(5'b01110);
        run(enc(2, 0, 1));
        check(ccr == 5'b01010, "R4 N V kept, R3 Z cleared", ccr, 5'b01010);
    endtask

    task automatic t_chain;
        logic [7:0]  d [3];
        logic [7:0]  s [3];
        logic [7:0]  ex [3];
        logic        x;
        logic        zacc;
        logic [8:0]  e;
        logic [31:0] v;
        d[0] = 8'h12; d[1] = 8'h34; d[2] = 8'h56;
        s[0] = 8'h23; s[1] = 8'h45; s[2] = 8'h67;
        for (int k = 0; k < 3; k++) begin
            mem_bytes[8'h40 + k] = d[k];
            mem_bytes[8'h50 + k] = s[k];
        end
        x = 1'b0; zacc = 1'b1;
        for (int k = 2; k >= 0; k--) begin
            e = ref_sub(d[k], s[k], x);
            ex[k] = e[7:0]; x = e[8];
            if (e[7:0] != 0) zacc = 1'b0;
        end
        set_reg(4'h8, 32'h53);
        set_reg(4'h9, 32'h43);
        set_ccr(5'b00100);
        stall = 1;
        for (int k = 0; k < 3; k++) begin
            log_n = 0;
            run(enc(1, 1, 0));
            if (k == 0)
                check(log_n == 3 && log_addr[0] == 32'h52 && !log_we[0] &&
                      log_addr[1] == 32'h42 && !log_we[1] &&
                      log_addr[2] == 32'h42 && log_we[2],
                      "R7 R8 access order", log_n, 3);
        end
        stall = 0;
        for (int k = 0; k < 3; k++)
            check(mem_bytes[8'h40 + k] == ex[k], "R1 chain byte", mem_bytes[8'h40 + k], ex[k]);
        check(ccr[0] == x && ccr[4] == x && ccr[2] == zacc, "R2 R3 chain flags",
              ccr, {x, 1'b0, zacc, 1'b0, x});
        get_reg(4'h8, v);
        check(v == 32'h50, "R9 source pointer after chain", v, 32'h50);
        get_reg(4'h9, v);
        check(v == 32'h40, "R9 dest pointer after chain", v, 32'h40);
    endtask

    task automatic t_step;
        logic [31:0] v;
        set_reg(4'hB, 32'h80);
        mem_bytes[8'h7F] = 8'h45;
        mem_bytes[8'h7E] = 8'h71;
        set_ccr(5'b00000);
        stall = 1;
        log_n = 0;
        run(enc(3, 1, 3));
        stall = 0;
        check(log_addr[0] == 32'h7F && log_addr[1] == 32'h7E && log_addr[2] == 32'h7E,
              "R9 same register stepped twice", log_addr[1], 32'h7E);
        check(mem_bytes[8'h7E] == 8'h26, "R1 same register result", mem_bytes[8'h7E], 8'h26);
        get_reg(4'hB, v);
        check(v == 32'h7E, "R9 same register final", v, 32'h7E);
        set_reg(4'hF, 32'h90);
        set_reg(4'h9, 32'hA0);
        log_n = 0;
        run(enc(1, 1, 7));
        check(log_addr[0] == 32'h8E && log_addr[1] == 32'h9F, "R9 step 2 for register 7",
              log_addr[0], 32'h8E);
        get_reg(4'hF, v);
        check(v == 32'h8E, "R9 register 7 final", v, 32'h8E);
    endtask

    task automatic t_illegal;
        logic [31:0] v;
        int          dc;
        set_reg(4'h0, 32'h11);
        set_reg(4'h1, 32'h99);
        set_ccr(5'b00100);
        dc = done_cnt;
        @(negedge clk);
        start = 1'b1; instr = enc(1, 0, 0) | 16'h0010;
        @(negedge clk);
        start = 1'b0;
        check(illegal == 1'b1, "R6 illegal pulse", illegal, 1);
        @(negedge clk);
        check(illegal == 1'b0, "R6 illegal one cycle", illegal, 0);
        repeat (4) @(negedge clk);
        get_reg(4'h1, v);
        check(v == 32'h99 && ccr == 5'b00100 && done_cnt == dc, "R6 no state change",
              v, 32'h99);
        @(negedge clk);
        start = 1'b1; instr = 16'h9101;
        @(negedge clk);
        start = 1'b0;
        check(illegal == 1'b1, "R6 bad top bits", illegal, 1);
    endtask

    task automatic t_busy;
        logic [31:0] v;
        int          dc;
        set_reg(4'h0, 32'h55);
        set_reg(4'h8, 32'h20);
        set_reg(4'h9, 32'h30);
        mem_bytes[8'h1F] = 8'h01;
        mem_bytes[8'h2F] = 8'h02;
        set_ccr(5'b00000);
        stall = 1;
        dc = done_cnt;
        @(negedge clk);
        start = 1'b1; instr = enc(1, 1, 0);
        @(negedge clk);
        instr = enc(0, 0, 0);
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        stall = 0;
        get_reg(4'h0, v);
        check(v == 32'h55 && done_cnt == dc + 1, "R10 start ignored while busy", v, 32'h55);
        check(mem_bytes[8'h2F] == 8'h01, "R1 busy run result", mem_bytes[8'h2F], 8'h01);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem_bytes[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_reg_basic;
        t_wrap;
        t_xin;
        t_sticky;
        t_nv;
        t_chain;
        t_step;
        t_illegal;
        t_busy;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule